// File: doc/BRIEF.md
# Synchronous Memory Access Sequencer

This block turns single-beat requests into the control sequence for an external synchronous memory. The memory can be a pipelined burst SRAM, a zero-turnaround SRAM, or a synchronous FIFO placed behind a little glue logic. A requester offers a read or a write together with an address, byte enables and write data. The requester waits for `req_ready`, and the request is taken on the clock edge where `req_valid` and `req_ready` are both high. The block then drives active-low chip enable, shared strobe, output enable and write enable. It holds the address and byte enables steady, and it presents the write data at the programmed write latency. It samples read data at the programmed read latency and returns it with a one-cycle valid pulse.

Four configuration inputs set the behaviour: read latency, write latency, chip-enable extension, and the role of the shared strobe. They are copied at acceptance, so each access runs entirely with the settings present when it was taken. The state machine has four states:
- `ST_IDLE`: ready for a request.
- `ST_CMD`: the one command cycle.
- `ST_WAIT`: counting down the latency.
- `ST_DESEL`: one deselect cycle, used in address-strobe mode only.

The transitions are:
- `ST_IDLE` to `ST_CMD` on accept.
- `ST_CMD` to `ST_WAIT` for a read, or for a write whose latency is nonzero.
- `ST_CMD` or `ST_WAIT` to the finish state when the last phase is done.
- `ST_DESEL` to `ST_IDLE`.

The finish state is `ST_DESEL` in address-strobe mode and `ST_IDLE` in FIFO mode. All outputs change on the rising edge of `clk`. `BASE_DLY` (default 2) is the fixed read pipeline delay of the memory.

Top module: `sync_mem_seq`

## Requirements
- R1: After reset, all four strobes read 1 (deasserted), `mem_dout_en` and `rd_valid` read 0, and `req_ready` reads 1.
- R2: A read issued in command cycle k samples `mem_din` at the end of cycle k+BASE_DLY+rd_lat. `rd_valid` is then 1 for exactly cycle k+BASE_DLY+rd_lat+1, with the sampled value on `rd_data`.
- R3: A write drives `mem_we_n`=0 only in its command cycle. `mem_dout_en`=1 for exactly one cycle, cycle k+wr_lat, with the request data on `mem_dout`.
- R4: With `cfg_ce_ext`=0, and always for writes, `mem_ce_n` is 0 only in the command cycle.
- R5: With `cfg_ce_ext`=1, a read keeps `mem_ce_n`=0 in every cycle in which `mem_oe_n`=0.
- R6: With `cfg_strobe_fifo`=0, `mem_ads_n` is 0 in the command cycle of every access. After the access, one deselect cycle follows, with `mem_ads_n`=0 and `mem_ce_n`=1, before `req_ready` returns.
- R7: With `cfg_strobe_fifo`=1, `mem_ads_n` is 0 only in the command cycle of a read, and no deselect cycle is inserted.
- R8: `mem_oe_n` is 0 from a read's command cycle through its sample cycle, and is never 0 during a write.
- R9: From the command cycle until the next command, `mem_addr` equals the request address and `mem_be_n` equals the bitwise inverse of the request byte enables.
- R10: `req_ready` is 1 only in idle. A request held valid during an access is taken only when the current access, including any deselect cycle, has finished.
- R11: A configuration change made after acceptance has no effect on the access already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_lat | input | 2 | Read latency 0..3 |
| cfg_wr_lat | input | 2 | Write latency 0..3 |
| cfg_ce_ext | input | 1 | 1: hold chip enable while output enable is active |
| cfg_strobe_fifo | input | 1 | 1: strobe acts as FIFO read enable, no deselect |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Request address |
| req_be | input | BW | Byte enables, active high |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Block can take a request |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_ads_n | output | 1 | Shared address strobe / read enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Memory address |
| mem_be_n | output | BW | Byte enables, active low |
| mem_dout | output | DW | Write data to memory |
| mem_dout_en | output | 1 | Write data drive enable |
| mem_din | input | DW | Read data from memory |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DW | Captured read data |

## Verification
Two things can fall in the same cycle: the read-data valid pulse of one access, and the return of `req_ready` or the deselect cycle at its end.

In FIFO mode, `rd_valid` rises in the very cycle that `req_ready` returns. The bench holds `req_valid` high across such an access, which lets the next command follow at once. It checks that the valid pulse, its data and the new chip-enable assertion each land in their own computed cycle.

The memory data bus is driven with a value that encodes the cycle offset. A capture one cycle early or late therefore shows as wrong data, not as a silent pass.

// File: rtl/sms_pkg.sv
package sms_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DESEL = 2'd3
    } sms_state_t;

    typedef struct packed {
        logic [1:0] rd_lat;
        logic [1:0] wr_lat;
        logic       ce_ext;
        logic       strobe_fifo;
    } sms_cfg_t;

endpackage

// File: rtl/sms_fsm.sv
module sms_fsm
    import sms_pkg::*;
#(
    parameter int BASE_DLY = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  logic     req_write,
    input  sms_cfg_t cfg_in,
    output logic     accept,
    output sms_cfg_t cfg_act,
    output logic     req_ready,
    output logic     ce_n,
    output logic     ads_n,
    output logic     oe_n,
    output logic     we_n,
    output logic     data_en,
    output logic     sample_en
);

    localparam int CW = $clog2(BASE_DLY + 4) + 1;

    sms_state_t     state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic           wr_q;
    logic           last_phase;
    logic           oe_int;

    assign accept = req_valid && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // latency counter and per-access configuration snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            cfg_act <= '0;
        end else begin
            if (accept) begin
                wr_q    <= req_write;
                cfg_act <= cfg_in;
            end
            if (state_q == ST_CMD) begin
                if (wr_q) cnt_q <= CW'(cfg_act.wr_lat) - CW'(1);
                else      cnt_q <= CW'(BASE_DLY) + CW'(cfg_act.rd_lat) - CW'(1);
            end else if (state_q == ST_WAIT && cnt_q != '0) begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    always_comb begin
        last_phase = ((state_q == ST_CMD) && wr_q && (cfg_act.wr_lat == 2'd0)) ||
                     ((state_q == ST_WAIT) && (cnt_q == '0));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_CMD;
            ST_CMD:   begin
                if (last_phase) state_d = cfg_act.strobe_fifo ? ST_IDLE : ST_DESEL;
                else            state_d = ST_WAIT;
            end
            ST_WAIT:  if (last_phase) state_d = cfg_act.strobe_fifo ? ST_IDLE : ST_DESEL;
            ST_DESEL: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        oe_int    = !wr_q && ((state_q == ST_CMD) || (state_q == ST_WAIT));
        oe_n      = !oe_int;
        we_n      = !((state_q == ST_CMD) && wr_q);
        ce_n      = !((state_q == ST_CMD) || (cfg_act.ce_ext && oe_int));
        if (cfg_act.strobe_fifo) ads_n = !((state_q == ST_CMD) && !wr_q);
        else                     ads_n = !((state_q == ST_CMD) || (state_q == ST_DESEL));
        data_en   = wr_q && last_phase;
        sample_en = !wr_q && (state_q == ST_WAIT) && (cnt_q == '0);
    end

endmodule

// File: rtl/sms_reqreg.sv
module sms_reqreg #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic [BW-1:0] be_in,
    input  logic [DW-1:0] wdata_in,
    output logic [AW-1:0] addr_q,
    output logic [BW-1:0] be_n_q,
    output logic [DW-1:0] wdata_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            be_n_q  <= '1;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= addr_in;
            be_n_q  <= ~be_in;
            wdata_q <= wdata_in;
        end
    end

endmodule

// File: rtl/sms_capture.sv
module sms_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_en,
    input  logic [DW-1:0] din,
    output logic          valid_q,
    output logic [DW-1:0] data_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= sample_en;
            if (sample_en) data_q <= din;
        end
    end

endmodule

// File: rtl/sync_mem_seq.sv
module sync_mem_seq
    import sms_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int BW       = DW / 8,
    parameter int BASE_DLY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_rd_lat,
    input  logic [1:0]    cfg_wr_lat,
    input  logic          cfg_ce_ext,
    input  logic          cfg_strobe_fifo,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [BW-1:0] req_be,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          mem_ce_n,
    output logic          mem_ads_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [BW-1:0] mem_be_n,
    output logic [DW-1:0] mem_dout,
    output logic          mem_dout_en,
    input  logic [DW-1:0] mem_din,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);

    sms_cfg_t cfg_in;
    sms_cfg_t cfg_act;
    logic     accept;
    logic     sample_en;

    assign cfg_in = '{rd_lat: cfg_rd_lat, wr_lat: cfg_wr_lat,
                      ce_ext: cfg_ce_ext, strobe_fifo: cfg_strobe_fifo};

    sms_fsm #(.BASE_DLY(BASE_DLY)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .cfg_in    (cfg_in),
        .accept    (accept),
        .cfg_act   (cfg_act),
        .req_ready (req_ready),
        .ce_n      (mem_ce_n),
        .ads_n     (mem_ads_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .data_en   (mem_dout_en),
        .sample_en (sample_en)
    );

    sms_reqreg #(.AW(AW), .DW(DW), .BW(BW)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .addr_in  (req_addr),
        .be_in    (req_be),
        .wdata_in (req_wdata),
        .addr_q   (mem_addr),
        .be_n_q   (mem_be_n),
        .wdata_q  (mem_dout)
    );

    sms_capture #(.DW(DW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .din       (mem_din),
        .valid_q   (rd_valid),
        .data_q    (rd_data)
    );

endmodule

// File: rtl/sms_checker.sv
module sms_checker
    import sms_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_ce_n,
    input logic          mem_ads_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dout_en,
    input logic [AW-1:0] mem_addr,
    input logic          req_ready,
    input logic          rd_valid,
    input sms_cfg_t      cfg_act
);

    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);                                             // R2
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> mem_we_n);                                             // R3
    AST_DOUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |=> !mem_dout_en);                                       // R3
    AST_CE_COVERS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && cfg_act.ce_ext) |-> !mem_ce_n);                        // R5
    AST_FIFO_NO_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_act.strobe_fifo && !mem_ads_n) |-> (!mem_ce_n && mem_we_n));    // R7
    AST_OE_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n);                                             // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(mem_addr));                                   // R9
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en));   // R10

endmodule

bind sync_mem_seq sms_checker #(.AW(AW)) u_sms_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_ce_n    (mem_ce_n),
    .mem_ads_n   (mem_ads_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_dout_en (mem_dout_en),
    .mem_addr    (mem_addr),
    .req_ready   (req_ready),
    .rd_valid    (rd_valid),
    .cfg_act     (cfg_act)
);

// File: tb/test_sync_mem_seq.sv
module test_sync_mem_seq;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int BW = 4;
    localparam int BASE = 2;

    typedef struct packed {
        logic        wr;
        logic [1:0]  rl;
        logic [1:0]  wl;
        logic        ce;
        logic        ff;
        logic [15:0] addr;
        logic [3:0]  be;
        logic [31:0] dat;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 16'h1234, 4'hF, 32'h0},
        '{1'b0, 2'd3, 2'd1, 1'b1, 1'b0, 16'hA5A5, 4'h3, 32'h0},
        '{1'b0, 2'd1, 2'd2, 1'b1, 1'b1, 16'h0F0F, 4'hC, 32'h0},
        '{1'b0, 2'd2, 2'd0, 1'b0, 1'b1, 16'hFFFE, 4'h1, 32'h0},
        '{1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 16'h4000, 4'hF, 32'hCAFE_0001},
        '{1'b1, 2'd0, 2'd3, 1'b0, 1'b1, 16'h0001, 4'h5, 32'h1357_9BDF},
        '{1'b1, 2'd2, 2'd2, 1'b1, 1'b0, 16'h8001, 4'hA, 32'hDEAD_BEEF},
        '{1'b1, 2'd3, 2'd1, 1'b0, 1'b1, 16'h7777, 4'h8, 32'h0000_FFFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_rd_lat = '0;
    logic [1:0]    cfg_wr_lat = '0;
    logic          cfg_ce_ext = 1'b0;
    logic          cfg_strobe_fifo = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [BW-1:0] req_be = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          mem_ce_n, mem_ads_n, mem_oe_n, mem_we_n;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] mem_be_n;
    logic [DW-1:0] mem_dout;
    logic          mem_dout_en;
    logic [DW-1:0] mem_din = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    sync_mem_seq #(.AW(AW), .DW(DW), .BW(BW), .BASE_DLY(BASE)) i_sync_mem_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_rd_lat(cfg_rd_lat), .cfg_wr_lat(cfg_wr_lat),
        .cfg_ce_ext(cfg_ce_ext), .cfg_strobe_fifo(cfg_strobe_fifo),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .req_ready(req_ready),
        .mem_ce_n(mem_ce_n), .mem_ads_n(mem_ads_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_be_n(mem_be_n),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One access, observed cycle by cycle from its command cycle (k = 0).
    // flip: change config ports at k = 1; hold: keep req_valid high.
    task automatic run_access(vec_t v, bit flip, bit hold);
        int s, fin, rdy_exp;
        int n_ce, n_oe, n_ads, n_we, n_den, den_k, rv_k, rdy_k;
        logic [31:0] den_val, rv_val;
        bit addr_ok, desel_ok, next_cmd;
        s   = BASE + int'(v.rl);
        fin = v.wr ? int'(v.wl) : s;
        rdy_exp = fin + 1 + (v.ff ? 0 : 1);
        n_ce = 0; n_oe = 0; n_ads = 0; n_we = 0; n_den = 0;
        den_k = -1; rv_k = -1; rdy_k = -1; den_val = '0; rv_val = '0;
        addr_ok = 1; desel_ok = v.ff; next_cmd = 0;
        @(negedge clk);
        cfg_rd_lat = v.rl; cfg_wr_lat = v.wl; cfg_ce_ext = v.ce; cfg_strobe_fifo = v.ff;
        req_valid = 1'b1; req_write = v.wr; req_addr = v.addr; req_be = v.be; req_wdata = v.dat;
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
        for (int k = 0; k < 14; k++) begin
            mem_din = 32'hD000_0000 | k;
            if (flip && k == 1) begin
                cfg_rd_lat = ~v.rl; cfg_wr_lat = ~v.wl;
                cfg_ce_ext = ~v.ce; cfg_strobe_fifo = ~v.ff;
            end
            if (rdy_k < 0) begin
                if (req_ready) rdy_k = k;
                else begin
                    if (!mem_ce_n)  n_ce++;
                    if (!mem_oe_n)  n_oe++;
                    if (!mem_ads_n) n_ads++;
                    if (!mem_we_n && k == 0) n_we++;
                    else if (!mem_we_n) n_we += 10;
                    if (mem_dout_en) begin n_den++; den_k = k; den_val = mem_dout; end
                    if (mem_addr !== v.addr || mem_be_n !== ~v.be) addr_ok = 0;
                    if (!v.ff && k == fin + 1 && !mem_ads_n && mem_ce_n) desel_ok = 1;
                end
            end
            if (rd_valid && rv_k < 0) begin rv_k = k; rv_val = rd_data; end
            if (hold && rdy_k >= 0 && k == rdy_k + 1 && !mem_ce_n) next_cmd = 1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        repeat (16) @(negedge clk);
        check("R4/R5", "chip-enable low cycles", n_ce, (!v.wr && v.ce) ? s + 1 : 1);
        check("R8", "output-enable low cycles", n_oe, v.wr ? 0 : s + 1);
        check("R6/R7", "strobe low cycles", n_ads, v.ff ? (v.wr ? 0 : 1) : 2);
        check("R6", "deselect cycle present", desel_ok, 1);
        check("R3", "write-enable pattern", n_we, v.wr ? 1 : 0);
        check("R3", "data-enable cycles", n_den, v.wr ? 1 : 0);
        if (v.wr) begin
            check("R3", "data-enable cycle index", den_k, v.wl);
            check("R3", "write data", den_val, v.dat);
        end else begin
            check("R2", "read valid cycle index", rv_k, s + 1);
            check("R2", "read data", rv_val, 32'hD000_0000 | s);
        end
        check("R9", "address/byte enables held", addr_ok, 1);
        check("R10", "ready return cycle", rdy_k, rdy_exp);
        if (flip) check("R11", "in-flight config unchanged", rdy_k, rdy_exp);
        if (hold) check("R10", "held request taken after finish", next_cmd, 1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, sampled while reset is still asserted
        check("R1", "strobes idle", {mem_ce_n, mem_ads_n, mem_oe_n, mem_we_n}, 4'hF);
        check("R1", "ready/valid/dout_en", {req_ready, rd_valid, mem_dout_en}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "strobes idle after release", {mem_ce_n, mem_ads_n, mem_oe_n, mem_we_n}, 4'hF);

        for (int i = 0; i < 8; i++) run_access(VEC[i], 1'b0, 1'b0);

        // R11: configuration flipped mid-access (read and write)
        run_access(VEC[0], 1'b1, 1'b0);
        run_access(VEC[5], 1'b1, 1'b0);
        // R10: request held valid across an access; FIFO read and address-mode write
        run_access(VEC[2], 1'b0, 1'b1);
        run_access(VEC[4], 1'b0, 1'b1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule